// File: doc/BRIEF.md
# Banked General Register File with Flag Word

This block keeps four 16-bit general registers, numbered 1 to 4, and a second, hidden copy of the same four. It also keeps a 16-bit flag word. The flag word holds a bank selector, two interrupt enables, a nesting enable, a 4-bit priority threshold, a 4-bit auxiliary field and three single-bit mode flags. Instruction decode drives the ports of the block. Two read ports and one write port reach the visible bank. A 32-bit pair port treats registers 3 and 4 as one value, with register 4 as the upper half.

A flag-word write can give the bank selector a new value. In that case the four visible registers and their hidden copies trade contents in the same clock edge. Software can then switch between two register contexts with a single flag-word write. A flag-word write that keeps the selector at its old value does not touch the registers. A register write in the same cycle as a bank flip is applied after the exchange, so it always lands in the bank that becomes visible.

Top module: `banked_regfile`

## Requirements
- R1: After reset all eight general registers (visible and hidden) read 0 and the flag word reads 16'h0808: the move-control bit (bit 11) is 1, the priority field (bits 3:0) is 8 and every other bit is 0.
- R2: A flag-word write stores bits 14:0 of the written word. From the next cycle the flag word reads back as those bits with bit 15 forced to 0.
- R3: The flag word has this bit layout: 14 quotient flag, 13 bank selector, 12 fraction mode, 11 move control, 10:7 auxiliary field, 6 fast-interrupt enable, 5 maskable-interrupt enable, 4 nesting enable, 3:0 priority.
- R4: If a flag-word write gives bit 13 a value different from its current value, registers 1 to 4 exchange contents with their hidden copies at that clock edge.
- R5: A flag-word write that leaves bit 13 at its current value does not change registers 1 to 4. When no write of any kind occurs, all register and flag values stay the same.
- R6: When `wr_en` is high, `wr_data` is written into the visible register selected by `wr_addr` (code 0 selects register 1, up to code 3 for register 4). The new value can be read from the next cycle.
- R7: When a bank flip and a register write (single or pair) happen in the same cycle, the exchange is done first. The write then lands in the newly visible bank, and the old visible value goes unchanged into the hidden copy.
- R8: `pair_rd_data` always shows {register 4, register 3}. A pair write loads register 3 from bits 15:0 and register 4 from bits 31:16.
- R9: When a single write and a pair write reach register 3 or 4 in the same cycle, the pair write wins for that register.
- R10: The read ports and the flag read are combinational. During a write cycle they return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | 4 | Two 2-bit read selects, port 0 in bits 1:0 |
| rd_data | output | 32 | Two 16-bit read results, port 0 in bits 15:0 |
| wr_en | input | 1 | Single-register write enable |
| wr_addr | input | 2 | Single write target, 0 selects register 1 |
| wr_data | input | 16 | Single write data |
| pair_wr_en | input | 1 | Pair write enable for registers 3 and 4 |
| pair_wr_data | input | 32 | Pair write data, register 4 in the upper half |
| pair_rd_data | output | 32 | {register 4, register 3} |
| flag_wr_en | input | 1 | Flag-word write enable |
| flag_wr_data | input | 16 | Flag-word write data |
| flag_rd_data | output | 16 | Current flag word |

## Verification
The case that matters most is a flag-word write that flips bit 13 in the same cycle as a single write, a pair write, or both. The bench drives this case on purpose with known register contents. It then flips the bank back and checks that the hidden bank kept the old visible values, while the written value sits in the bank that was visible after the flip. A random phase also mixes flag writes with both write ports. A behavioural model applies exchange-then-write in every cycle, and all outputs are compared against it.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int unsigned NGPR     = 4;
    localparam int unsigned IDX_W    = 2;
    localparam int unsigned FLAG_W   = 16;
    localparam int unsigned PAIR_LO  = 2;
    localparam int unsigned PAIR_HI  = 3;

    // Declaration order matches the word layout, bit 14 down to bit 0.
    typedef struct packed {
        logic       qflag;
        logic       bank_sel;
        logic       frac_mode;
        logic       move_ctl;
        logic [3:0] aux4;
        logic       fast_en;
        logic       irq_en;
        logic       nest_en;
        logic [3:0] prio_lvl;
    } flag_t;

    localparam flag_t FLAG_RST = '{
        qflag: 1'b0, bank_sel: 1'b0, frac_mode: 1'b0, move_ctl: 1'b1,
        aux4: 4'd0, fast_en: 1'b0, irq_en: 1'b0, nest_en: 1'b0,
        prio_lvl: 4'd8
    };

endpackage

// File: rtl/flag_codec.sv
module flag_codec
    import regbank_pkg::*;
(
    input  logic [FLAG_W-1:0] word_in,
    input  logic              load,
    input  flag_t             cur,
    output flag_t             fields_out,
    output logic              bank_flip,
    output logic [FLAG_W-1:0] word_out
);

    always_comb begin
        fields_out = flag_t'(word_in[FLAG_W-2:0]);
        bank_flip  = load && (fields_out.bank_sel != cur.bank_sel);
        word_out   = {1'b0, cur};
    end

endmodule

// File: rtl/gpr_read_mux.sv
module gpr_read_mux
    import regbank_pkg::*;
#(
    parameter int unsigned DW  = 16,
    parameter int unsigned NRD = 2
) (
    input  logic [NGPR-1:0][DW-1:0] regs,
    input  logic [NRD*IDX_W-1:0]    addr,
    output logic [NRD*DW-1:0]       data
);

    for (genvar p = 0; p < NRD; p++) begin : g_port
        assign data[p*DW +: DW] = regs[addr[p*IDX_W +: IDX_W]];
    end

endmodule

// File: rtl/bank_next.sv
module bank_next
    import regbank_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic [NGPR-1:0][DW-1:0] act_q,
    input  logic [NGPR-1:0][DW-1:0] shd_q,
    input  logic                    swap,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic                    pair_en,
    input  logic [2*DW-1:0]         pair_data,
    output logic [NGPR-1:0][DW-1:0] act_d,
    output logic [NGPR-1:0][DW-1:0] shd_d
);

    for (genvar i = 0; i < NGPR; i++) begin : g_reg
        always_comb begin
            // exchange first, then port writes into the new visible bank
            act_d[i] = swap ? shd_q[i] : act_q[i];
            shd_d[i] = swap ? act_q[i] : shd_q[i];
            if (wr_en && (wr_addr == IDX_W'(i))) begin
                act_d[i] = wr_data;
            end
            if (pair_en && (i == PAIR_LO)) begin
                act_d[i] = pair_data[DW-1:0];
            end
            if (pair_en && (i == PAIR_HI)) begin
                act_d[i] = pair_data[2*DW-1:DW];
            end
        end
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import regbank_pkg::*;
#(
    parameter int unsigned DW  = 16,
    parameter int unsigned NRD = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NRD*IDX_W-1:0] rd_addr,
    output logic [NRD*DW-1:0]    rd_data,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic                 pair_wr_en,
    input  logic [2*DW-1:0]      pair_wr_data,
    output logic [2*DW-1:0]      pair_rd_data,
    input  logic                 flag_wr_en,
    input  logic [FLAG_W-1:0]    flag_wr_data,
    output logic [FLAG_W-1:0]    flag_rd_data
);

    typedef struct packed {
        logic [NGPR-1:0][DW-1:0] act;
        logic [NGPR-1:0][DW-1:0] shd;
        flag_t                   flg;
    } state_t;

    state_t state_d, state_q;

    flag_t                   flg_new_d;
    logic                    flip_d;
    logic [NGPR-1:0][DW-1:0] act_nx_d, shd_nx_d;

    flag_codec u_codec (
        .word_in    (flag_wr_data),
        .load       (flag_wr_en),
        .cur        (state_q.flg),
        .fields_out (flg_new_d),
        .bank_flip  (flip_d),
        .word_out   (flag_rd_data)
    );

    bank_next #(.DW(DW)) u_next (
        .act_q     (state_q.act),
        .shd_q     (state_q.shd),
        .swap      (flip_d),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pair_en   (pair_wr_en),
        .pair_data (pair_wr_data),
        .act_d     (act_nx_d),
        .shd_d     (shd_nx_d)
    );

    gpr_read_mux #(.DW(DW), .NRD(NRD)) u_rd (
        .regs (state_q.act),
        .addr (rd_addr),
        .data (rd_data)
    );

    assign pair_rd_data = {state_q.act[PAIR_HI], state_q.act[PAIR_LO]};

    always_comb begin
        state_d     = state_q;
        state_d.act = act_nx_d;
        state_d.shd = shd_nx_d;
        if (flag_wr_en) begin
            state_d.flg = flg_new_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.act <= '0;
            state_q.shd <= '0;
            state_q.flg <= FLAG_RST;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/regbank_checker.sv
module regbank_checker
    import regbank_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              pair_wr_en,
    input logic [2*DW-1:0]   pair_wr_data,
    input logic [2*DW-1:0]   pair_rd_data,
    input logic              flag_wr_en,
    input logic [FLAG_W-1:0] flag_wr_data,
    input logic [FLAG_W-1:0] flag_rd_data
);

    p_top_bit_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd_data[FLAG_W-1] == 1'b0);

    p_flag_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr_en |=> flag_rd_data == {1'b0, $past(flag_wr_data[FLAG_W-2:0])});

    p_same_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr_en && (flag_wr_data[13] == flag_rd_data[13]) && !wr_en && !pair_wr_en)
        |=> $stable(pair_rd_data));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr_en && !wr_en && !pair_wr_en)
        |=> ($stable(pair_rd_data) && $stable(flag_rd_data)));

    // R7: the pair value survives a simultaneous flip
    p_pair_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pair_wr_en |=> pair_rd_data == $past(pair_wr_data));

    p_pair_over_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_wr_en && wr_en) |=> pair_rd_data == $past(pair_wr_data));

endmodule

bind banked_regfile regbank_checker #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .pair_wr_en   (pair_wr_en),
    .pair_wr_data (pair_wr_data),
    .pair_rd_data (pair_rd_data),
    .flag_wr_en   (flag_wr_en),
    .flag_wr_data (flag_wr_data),
    .flag_rd_data (flag_rd_data)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pair_wr_en = 1'b0;
    logic [31:0] pair_wr_data = '0;
    logic [31:0] pair_rd_data;
    logic        flag_wr_en = 1'b0;
    logic [15:0] flag_wr_data = '0;
    logic [15:0] flag_rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural reference state
    logic [15:0] m_vis [4];
    logic [15:0] m_hid [4];
    logic [15:0] m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile u_banked_regfile (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pair_wr_en(pair_wr_en), .pair_wr_data(pair_wr_data),
        .pair_rd_data(pair_rd_data), .flag_wr_en(flag_wr_en),
        .flag_wr_data(flag_wr_data), .flag_rd_data(flag_rd_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk(req, "read port 0", {16'h0, rd_data[15:0]}, {16'h0, m_vis[rd_addr[1:0]]});
        chk(req, "read port 1", {16'h0, rd_data[31:16]}, {16'h0, m_vis[rd_addr[3:2]]});
        chk(req, "pair read R8", pair_rd_data, {m_vis[3], m_vis[2]});
        chk(req, "flag word R2", {16'h0, flag_rd_data}, {16'h0, m_flag});
    endtask

    // one clock: drive, compare against pre-edge model (R10), advance model
    task automatic step(input bit we, input logic [1:0] wa, input logic [15:0] wd,
                        input bit pe, input logic [31:0] pd,
                        input bit fe, input logic [15:0] fd,
                        input logic [1:0] ra0, input logic [1:0] ra1,
                        input string req);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        pair_wr_en = pe; pair_wr_data = pd;
        flag_wr_en = fe; flag_wr_data = fd;
        rd_addr = {ra1, ra0};
        #1;
        compare(req);
        if (fe && (fd[13] != m_flag[13])) begin
            for (int k = 0; k < 4; k++) begin
                logic [15:0] t;
                t = m_vis[k]; m_vis[k] = m_hid[k]; m_hid[k] = t;
            end
        end
        if (we) m_vis[wa] = wd;
        if (pe) begin
            m_vis[2] = pd[15:0];
            m_vis[3] = pd[31:16];
        end
        if (fe) m_flag = {1'b0, fd[14:0]};
        @(posedge clk);
    endtask

    task automatic idle(input logic [1:0] ra0, input logic [1:0] ra1, input string req);
        step(0, 2'd0, 16'h0, 0, 32'h0, 0, 16'h0, ra0, ra1, req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            m_vis[k] = 16'h0; m_hid[k] = 16'h0;
        end
        m_flag = 16'h0808;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, all visible regs then hidden bank
        idle(2'd0, 2'd1, "R1");
        idle(2'd2, 2'd3, "R1");
        chk("R1", "reset flag word", {16'h0, flag_rd_data}, 32'h0000_0808);
        step(0, 2'd0, 16'h0, 0, 32'h0, 1, 16'h2808, 2'd0, 2'd1, "R1");
        idle(2'd0, 2'd1, "R1");
        idle(2'd2, 2'd3, "R1");
        step(0, 2'd0, 16'h0, 0, 32'h0, 1, 16'h0808, 2'd0, 2'd1, "R1");

        // R6: single writes to each register
        step(1, 2'd0, 16'h1111, 0, 32'h0, 0, 16'h0, 2'd0, 2'd0, "R6");
        step(1, 2'd1, 16'h2222, 0, 32'h0, 0, 16'h0, 2'd0, 2'd1, "R6");
        step(1, 2'd2, 16'h3333, 0, 32'h0, 0, 16'h0, 2'd1, 2'd2, "R6");
        step(1, 2'd3, 16'h4444, 0, 32'h0, 0, 16'h0, 2'd2, 2'd3, "R10");
        idle(2'd3, 2'd0, "R6");

        // R2/R5: bit 15 dropped, bank bit unchanged
        step(0, 2'd0, 16'h0, 0, 32'h0, 1, 16'hDFFF, 2'd0, 2'd1, "R5");
        idle(2'd2, 2'd3, "R5");
        chk("R2", "bit 15 cleared", {16'h0, flag_rd_data}, 32'h0000_5FFF);
        // R3: isolated fields
        step(0, 2'd0, 16'h0, 0, 32'h0, 1, 16'h0040, 2'd0, 2'd1, "R3");
        idle(2'd0, 2'd1, "R3");
        chk("R3", "fast enable bit 6 only", {16'h0, flag_rd_data}, 32'h0000_0040);
        step(0, 2'd0, 16'h0, 0, 32'h0, 1, 16'h0785, 2'd0, 2'd1, "R3");

        // R4: flip to hidden bank (zeros), fill it, flip back
        step(0, 2'd0, 16'h0, 0, 32'h0, 1, 16'h2000, 2'd0, 2'd1, "R4");
        idle(2'd0, 2'd1, "R4");
        chk("R4", "hidden bank visible", {16'h0, rd_data[15:0]}, 32'h0);
        step(1, 2'd1, 16'hBEEF, 0, 32'h0, 0, 16'h0, 2'd2, 2'd3, "R4");
        step(0, 2'd0, 16'h0, 0, 32'h0, 1, 16'h0000, 2'd0, 2'd1, "R4");
        idle(2'd0, 2'd1, "R4");
        chk("R4", "first bank restored R1", {16'h0, rd_data[15:0]}, 32'h0000_1111);

        // R7: flip with simultaneous single and pair writes
        step(1, 2'd0, 16'hA5A5, 1, 32'hCAFE_F00D, 1, 16'h2000, 2'd0, 2'd1, "R7");
        idle(2'd0, 2'd1, "R7");
        chk("R7", "write in new bank", {16'h0, rd_data[15:0]}, 32'h0000_A5A5);
        chk("R7", "pair in new bank", pair_rd_data, 32'hCAFE_F00D);
        step(0, 2'd0, 16'h0, 0, 32'h0, 1, 16'h0000, 2'd0, 2'd1, "R7");
        idle(2'd2, 2'd3, "R7");
        chk("R7", "old bank untouched", pair_rd_data, 32'h4444_3333);

        // R8/R9: pair write, and pair overriding single write
        step(0, 2'd0, 16'h0, 1, 32'h1234_5678, 0, 16'h0, 2'd2, 2'd3, "R8");
        step(1, 2'd3, 16'h9999, 1, 32'h0BAD_C0DE, 0, 16'h0, 2'd2, 2'd3, "R9");
        idle(2'd3, 2'd2, "R9");
        chk("R9", "pair wins on R4", {16'h0, rd_data[15:0]}, 32'h0000_0BAD);
        step(1, 2'd0, 16'h7777, 1, 32'h0101_0202, 0, 16'h0, 2'd0, 2'd2, "R9");
        idle(2'd0, 2'd2, "R9");

        // R10 and mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[2:1], $urandom, r[3] & r[4], $urandom,
                 r[5] & r[6], 16'($urandom), r[8:7], r[10:9], "R10");
        end
        idle(2'd0, 2'd1, "R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule